// File: doc/BRIEF.md
# NVM Command Register and Sequencer

This block is the control register of a non-volatile memory controller, together with the small sequencer behind it. Software writes one 8-bit register to pick a memory region and choose erase or program. It also opens the program gate and fires a write or read command. The sequencer turns a fired command into a single request on the memory side, waits for the memory's done pulse and loads read data into a data register. It then clears the command bit, so software polls that bit to learn when the operation is over.

Commands are checked before they leave the block. A write is refused if the program gate is closed, or if the address top bit does not match the selected region. A refused write sends no request and raises a sticky error flag. The same flag records a write that a warm reset cut short. Only one memory operation is outstanding at a time. A command raised while another is in flight waits its turn.

The memory-side interface is a plain pulse handshake, not a valid/ready stream. `mem_req` is high for exactly one cycle per operation, and its companion fields stay steady until the next request. The memory side answers with one `mem_done` pulse, which may come in any later cycle. There is no back-pressure: a new request is never issued before the previous one has been answered.

Top module: `nvm_cmd_seq`

## Requirements
- R1: The register reads back as {region[1:0] at bits 7:6, erase select at bit 5, error at bit 4, program enable at bit 3, write command at bit 2, read command at bit 1, 0 at bit 0}. A software write loads region, erase select and program enable directly.
- R2: Power-on reset (`por_n` low) clears every register bit, the data register and `mem_req`.
- R3: Writing 0 to the write or read command bit never clears it. Writing 1 sets it.
- R4: A write command with program enable 1 and a valid address produces a one-cycle `mem_req` with `mem_write`=1, `mem_erase` = erase select, and the region, address and write data. The request appears in the cycle after the command bit becomes visible.
- R5: The write command bit reads 1 while the operation is in flight and is cleared by the edge that samples `mem_done`.
- R6: A read command produces a request with `mem_write`=0. On `mem_done`, the data register takes `mem_rdata` and the read command bit clears.
- R7: A write command while program enable is 0 issues no request, clears the write command bit and sets the error bit.
- R8: A write in region 10 needs address top bit 0. A write in region x1 (bit 6 set) needs address top bit 1. Region 00 has no such rule. A mismatch issues no request and sets the error bit.
- R9: A warm reset (`wrst_n` low, synchronous) clears all bits except the error bit, and also clears the data register. It sets the error bit if a write was in flight and leaves it unchanged otherwise. An in-flight request is abandoned.
- R10: The error bit is cleared only by a software write with bit 4 = 0 or by power-on reset. Writing 1 there has no effect.
- R11: At most one operation is outstanding. When both commands are pending, the write goes first. A read raised during a write is issued after the write completes.
- R12: A `mem_done` pulse while no operation is in flight changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wrst_n | input | 1 | Warm reset, synchronous, active low |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| nvm_addr | input | ADDR_W | Target address of the next command |
| nvm_wdata | input | DATA_W | Data for the next program operation |
| nvm_dat | output | DATA_W | Data register, loaded by reads |
| mem_req | output | 1 | One-cycle request pulse |
| mem_region | output | 2 | Region of the request |
| mem_addr | output | ADDR_W | Address of the request |
| mem_erase | output | 1 | 1 = erase, 0 = program (writes only) |
| mem_write | output | 1 | 1 = program/erase, 0 = read |
| mem_wdata | output | DATA_W | Program data |
| mem_done | input | 1 | Completion pulse from the memory side |
| mem_rdata | input | DATA_W | Read data, valid with `mem_done` |

## Verification
The embedded properties assume three things about the memory side. It returns at most one `mem_done` per request, and never in the cycle of the request edge itself. The warm reset is synchronous. Software register writes may land in any cycle, including cycles in which a command is in flight. The stimulus uses a single responder that answers each request once, after a fixed delay or not at all. Stray done pulses are injected only while the sequencer is idle, and the warm reset is driven low for whole clock cycles, away from the edge.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
  localparam int unsigned B_RGN_HI = 7;
  localparam int unsigned B_RGN_LO = 6;
  localparam int unsigned B_ERASE  = 5;
  localparam int unsigned B_ERR    = 4;
  localparam int unsigned B_PGMEN  = 3;
  localparam int unsigned B_WRCMD  = 2;
  localparam int unsigned B_RDCMD  = 1;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WRITE = 2'd1,
    SQ_READ  = 2'd2
  } sq_state_t;

  // Region 00: no rule; region 10: top bit must be 0; region x1: top bit must be 1.
  function automatic logic space_ok(input logic [1:0] rgn, input logic top_bit);
    if (rgn[0])            return top_bit;
    else if (rgn == 2'b10) return !top_bit;
    else                   return 1'b1;
  endfunction
endpackage

// File: rtl/nvm_csr.sv
module nvm_csr
  import nvm_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       wrst_n,
  input  logic       sw_we,
  input  logic [7:1] sw_wdata,
  input  logic       wr_clr,
  input  logic       rd_clr,
  input  logic       err_set,
  output logic [1:0] region,
  output logic       erase_sel,
  output logic       err_flag,
  output logic       pgm_en,
  output logic       wr_cmd,
  output logic       rd_cmd
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      region    <= '0;
      erase_sel <= 1'b0;
      err_flag  <= 1'b0;
      pgm_en    <= 1'b0;
      wr_cmd    <= 1'b0;
      rd_cmd    <= 1'b0;
    end else if (!wrst_n) begin
      region    <= '0;
      erase_sel <= 1'b0;
      pgm_en    <= 1'b0;
      wr_cmd    <= 1'b0;
      rd_cmd    <= 1'b0;
      err_flag  <= err_flag | err_set;
    end else begin
      if (sw_we) begin
        region    <= sw_wdata[B_RGN_HI:B_RGN_LO];
        erase_sel <= sw_wdata[B_ERASE];
        pgm_en    <= sw_wdata[B_PGMEN];
      end
      // hardware set wins over a software clear in the same cycle
      if (err_set)
        err_flag <= 1'b1;
      else if (sw_we && !sw_wdata[B_ERR])
        err_flag <= 1'b0;
      // software set wins over a hardware clear in the same cycle
      wr_cmd <= (sw_we && sw_wdata[B_WRCMD]) || (wr_cmd && !wr_clr);
      rd_cmd <= (sw_we && sw_wdata[B_RDCMD]) || (rd_cmd && !rd_clr);
    end
  end

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    wr_cmd && !wr_clr |=> wr_cmd);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    rd_cmd && !rd_clr |=> rd_cmd);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    err_flag && !(sw_we && !sw_wdata[B_ERR] && wrst_n) |=> err_flag);

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic [1:0]        region,
  input  logic              erase_sel,
  input  logic              pgm_en,
  input  logic              wr_cmd,
  input  logic              rd_cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [1:0]        mem_region,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_erase,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] dat,
  output logic              wr_clr,
  output logic              rd_clr,
  output logic              err_set
);

  localparam int unsigned SPACE_BIT = ADDR_W - 1;

  sq_state_t state;
  logic idle, addr_good, start_w, bad_w, start_r;

  assign idle      = (state == SQ_IDLE);
  assign addr_good = space_ok(region, addr[SPACE_BIT]);
  assign start_w   = idle && wr_cmd && pgm_en && addr_good;
  assign bad_w     = idle && wr_cmd && !(pgm_en && addr_good) && wrst_n;
  assign start_r   = idle && !wr_cmd && rd_cmd;

  assign wr_clr  = bad_w || (state == SQ_WRITE && mem_done);
  assign rd_clr  = (state == SQ_READ) && mem_done;
  assign err_set = bad_w || (state == SQ_WRITE && !wrst_n);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state      <= SQ_IDLE;
      mem_req    <= 1'b0;
      mem_region <= '0;
      mem_addr   <= '0;
      mem_erase  <= 1'b0;
      mem_write  <= 1'b0;
      mem_wdata  <= '0;
      dat        <= '0;
    end else if (!wrst_n) begin
      state   <= SQ_IDLE;
      mem_req <= 1'b0;
      dat     <= '0;
    end else begin
      mem_req <= start_w || start_r;
      if (start_w || start_r) begin
        mem_region <= region;
        mem_addr   <= addr;
        mem_erase  <= erase_sel && start_w;
        mem_write  <= start_w;
        mem_wdata  <= wdata;
      end
      unique case (state)
        SQ_IDLE: begin
          if (start_w)      state <= SQ_WRITE;
          else if (start_r) state <= SQ_READ;
        end
        SQ_WRITE: if (mem_done) state <= SQ_IDLE;
        SQ_READ: begin
          if (mem_done) begin
            dat   <= mem_rdata;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    mem_req |=> !mem_req);
  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    mem_req |-> $past(state) == SQ_IDLE);
  // R7
  gate_closed_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    idle && wr_cmd && !pgm_en |=> !mem_req);
  // R8
  space_flash_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    idle && wr_cmd && region == 2'b10 && addr[SPACE_BIT] |=> !mem_req);
  // R6
  read_load_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    state == SQ_READ && mem_done |=> dat == $past(mem_rdata));
  // R12
  stray_done_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    idle && mem_done |=> $stable(dat));

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic              csr_we,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic [ADDR_W-1:0] nvm_addr,
  input  logic [DATA_W-1:0] nvm_wdata,
  output logic [DATA_W-1:0] nvm_dat,
  output logic              mem_req,
  output logic [1:0]        mem_region,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_erase,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [1:0] region;
  logic erase_sel, err_flag, pgm_en, wr_cmd, rd_cmd;
  logic wr_clr, rd_clr, err_set;
  logic unused_bit0;

  assign unused_bit0 = csr_wdata[0];

  nvm_csr u_csr (
    .clk       (clk),
    .por_n     (por_n),
    .wrst_n    (wrst_n),
    .sw_we     (csr_we),
    .sw_wdata  (csr_wdata[7:1]),
    .wr_clr    (wr_clr),
    .rd_clr    (rd_clr),
    .err_set   (err_set),
    .region    (region),
    .erase_sel (erase_sel),
    .err_flag  (err_flag),
    .pgm_en    (pgm_en),
    .wr_cmd    (wr_cmd),
    .rd_cmd    (rd_cmd)
  );

  nvm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .wrst_n     (wrst_n),
    .region     (region),
    .erase_sel  (erase_sel),
    .pgm_en     (pgm_en),
    .wr_cmd     (wr_cmd),
    .rd_cmd     (rd_cmd),
    .addr       (nvm_addr),
    .wdata      (nvm_wdata),
    .mem_done   (mem_done),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_region (mem_region),
    .mem_addr   (mem_addr),
    .mem_erase  (mem_erase),
    .mem_write  (mem_write),
    .mem_wdata  (mem_wdata),
    .dat        (nvm_dat),
    .wr_clr     (wr_clr),
    .rd_clr     (rd_clr),
    .err_set    (err_set)
  );

  assign csr_rdata = {region, erase_sel, err_flag, pgm_en, wr_cmd, rd_cmd, 1'b0};

  // R9
  warm_abort_chk: assert property (@(posedge clk) disable iff (!por_n)
    !wrst_n |=> !wr_cmd && !rd_cmd && !mem_req);

endmodule

// File: tb/nvm_cmd_seq_tb.sv
module nvm_cmd_seq_tb;
  localparam int unsigned AW = 22;
  localparam int unsigned DW = 8;
  localparam int unsigned RSP_DLY = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, wrst_n = 1'b1;
  logic csr_we = 1'b0;
  logic [7:0] csr_wdata = '0, csr_rdata;
  logic [AW-1:0] nvm_addr = '0, mem_addr;
  logic [DW-1:0] nvm_wdata = '0, nvm_dat, mem_wdata, rsp_rdata = '0;
  logic mem_req, mem_erase, mem_write;
  logic [1:0] mem_region;
  logic rsp_done = 1'b0, inj_done = 1'b0, resp_hold = 1'b0;
  logic mem_done;
  int n_chk = 0, n_fail = 0;

  typedef struct packed {
    logic [1:0]    region;
    logic [AW-1:0] addr;
    logic          erase;
    logic          write;
    logic [DW-1:0] wdata;
  } req_t;
  req_t exp_q[$];

  assign mem_done = rsp_done | inj_done;
  always #4 clk = ~clk;

  nvm_cmd_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .nvm_addr(nvm_addr),
    .nvm_wdata(nvm_wdata), .nvm_dat(nvm_dat), .mem_req(mem_req),
    .mem_region(mem_region), .mem_addr(mem_addr), .mem_erase(mem_erase),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_done(mem_done),
    .mem_rdata(rsp_rdata)
  );

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    return a[DW-1:0] ^ 8'hC3;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] r, input logic [AW-1:0] a,
                      input logic e, input logic w, input logic [DW-1:0] d);
    req_t it;
    it.region = r; it.addr = a; it.erase = e; it.write = w; it.wdata = w ? d : '0;
    exp_q.push_back(it);
  endtask

  task automatic cpu_wr(input logic [7:0] v);
    @(negedge clk); csr_we = 1'b1; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (csr_rdata[2:1] == 2'b00) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor and responder: pops the scoreboard on each request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        req_t got;
        got.region = mem_region; got.addr = mem_addr; got.erase = mem_erase;
        got.write = mem_write; got.wdata = mem_write ? mem_wdata : '0;
        if (exp_q.size() == 0) chk("R11 unexpected request", got, 0);
        else chk("R4/R6 request fields", got, exp_q.pop_front());
        if (!resp_hold) begin
          repeat (RSP_DLY - 1) @(negedge clk);
          rsp_done = 1'b1; rsp_rdata = rd_model(mem_addr);
          @(negedge clk);
          rsp_done = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [DW-1:0] saved;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R2 register after POR", csr_rdata, 8'h00);
    chk("R2 mem_req after POR", mem_req, 0);
    chk("R2 data after POR", nvm_dat, 0);

    // R1 layout, bit 0 reads 0
    cpu_wr(8'hA9);
    chk("R1 readback", csr_rdata, 8'hA8);

    // R4 flash program, R3 zero write keeps command, R5 busy/clear
    nvm_addr = 22'h001234; nvm_wdata = 8'h5A;
    push(2'b10, 22'h001234, 1'b0, 1'b1, 8'h5A);
    cpu_wr(8'h8C);
    chk("R5 write busy", csr_rdata[2], 1);
    cpu_wr(8'h88);
    chk("R3 write cmd kept", csr_rdata[2], 1);
    wait_idle();
    chk("R5 write cleared", csr_rdata, 8'h88);

    // R4 erase, R8 region 00 ignores top bit
    nvm_addr = 22'h3FFFFF; nvm_wdata = 8'h11;
    push(2'b00, 22'h3FFFFF, 1'b1, 1'b1, 8'h11);
    cpu_wr(8'h2C);
    wait_idle();
    chk("R8 eeprom no error", csr_rdata, 8'h28);

    // R6 read in region 01
    nvm_addr = 22'h20005A;
    push(2'b01, 22'h20005A, 1'b0, 1'b0, 8'h00);
    cpu_wr(8'h4A);
    chk("R3 read cmd set", csr_rdata[1], 1);
    wait_idle();
    chk("R6 data loaded", nvm_dat, rd_model(22'h20005A));
    chk("R6 read cleared", csr_rdata, 8'h48);

    // R7 gate closed
    nvm_addr = 22'h000100;
    cpu_wr(8'h84);
    repeat (4) @(negedge clk);
    chk("R7 gated write", csr_rdata, 8'h90);

    // R10 writing 1 keeps, 0 clears
    cpu_wr(8'h98);
    chk("R10 write 1 keeps error", csr_rdata[4], 1);
    cpu_wr(8'h88);
    chk("R10 write 0 clears error", csr_rdata[4], 0);

    // R8 mismatches
    nvm_addr = 22'h200010;
    cpu_wr(8'h8C);
    repeat (4) @(negedge clk);
    chk("R8 flash top bit 1", csr_rdata, 8'h98);
    cpu_wr(8'h48);
    nvm_addr = 22'h000010;
    cpu_wr(8'h4C);
    repeat (4) @(negedge clk);
    chk("R8 id space top bit 0", csr_rdata, 8'h58);
    nvm_addr = 22'h200020; nvm_wdata = 8'h77;
    push(2'b11, 22'h200020, 1'b0, 1'b1, 8'h77);
    cpu_wr(8'hCC);
    wait_idle();
    chk("R8 id space valid", csr_rdata, 8'hC8);

    // R11 read raised during write, then both at once
    nvm_addr = 22'h000044; nvm_wdata = 8'h99;
    push(2'b10, 22'h000044, 1'b0, 1'b1, 8'h99);
    push(2'b10, 22'h000044, 1'b0, 1'b0, 8'h00);
    cpu_wr(8'h8C);
    cpu_wr(8'h8A);
    chk("R11 both pending", csr_rdata[2:1], 2'b11);
    wait_idle();
    chk("R11 read after write", nvm_dat, rd_model(22'h000044));
    nvm_addr = 22'h000066; nvm_wdata = 8'h3C;
    push(2'b10, 22'h000066, 1'b1, 1'b1, 8'h3C);
    push(2'b10, 22'h000066, 1'b0, 1'b0, 8'h00);
    cpu_wr(8'hAE);
    wait_idle();
    chk("R11 write first then read", nvm_dat, rd_model(22'h000066));

    // R12 stray done while idle
    saved = nvm_dat;
    @(negedge clk); inj_done = 1'b1; rsp_rdata = 8'hEE;
    @(negedge clk); inj_done = 1'b0;
    @(negedge clk);
    chk("R12 data unchanged", nvm_dat, saved);
    chk("R12 register unchanged", csr_rdata, 8'hA8);

    // R9 warm reset during a write
    resp_hold = 1'b1;
    nvm_addr = 22'h001000; nvm_wdata = 8'h42;
    push(2'b10, 22'h001000, 1'b0, 1'b1, 8'h42);
    cpu_wr(8'h8C);
    repeat (3) @(negedge clk);
    wrst_n = 1'b0;
    @(negedge clk); wrst_n = 1'b1;
    @(negedge clk);
    chk("R9 abort sets error", csr_rdata, 8'h10);
    chk("R9 data cleared", nvm_dat, 0);
    resp_hold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no further request", mem_req, 0);
    wrst_n = 1'b0;
    @(negedge clk); wrst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle warm reset keeps error", csr_rdata, 8'h10);
    cpu_wr(8'h00);
    wrst_n = 1'b0;
    @(negedge clk); wrst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle warm reset no error", csr_rdata, 8'h00);

    // R2 power-on reset clears the error flag
    cpu_wr(8'h84);
    repeat (3) @(negedge clk);
    chk("R7 error before POR", csr_rdata[4], 1);
    por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    chk("R2 POR clears all", csr_rdata, 8'h00);

    chk("R11 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule